// File: doc/BRIEF.md
# SRTS Residual Time Stamp Generator

This block produces the 4-bit residual time stamp that an AAL1 transmitter sends so the far end can recover the source clock. It runs on the system clock. A divided-down network reference clock comes in as a plain level signal. It is oversampled through a synchronizer, and each rising edge advances a free-running residue counter that wraps modulo 16.

A second counter counts one-cycle service byte strobes. It runs up to a programmable terminal count, which is the number of payload bytes in one 8-cell period. Typical values are 376 for pointerless structured transfer (8 × 47) and 375 when one cell of the eight carries a pointer byte (46 + 7 × 47). On the strobe that completes a period, the current residue is captured into a five-entry first-in first-out queue. The cell transmit logic pops values from that queue when it builds headers. Sticky flags record captures lost to a full queue and pops made on an empty one.

Top module: `rts_stamp_gen`

## Requirements
- R1: Each low-to-high transition of `ref_clk_in` increments a 4-bit residue counter by one, wrapping from 15 to 0. Each level of the reference must be held for at least 2 system clock cycles, which keeps its frequency below one third of the system clock.
- R2: A capture pushes the current residue into the queue on the `byte_stb` strobe that is the N-th since the previous capture or since reset, where N is the active terminal count. Strobes before that one push nothing.
- R3: The active terminal count is loaded from `term_count` during reset and again at each capture. A change on `term_count` in mid-period does not alter the length of the period in progress.
- R4: Terminal counts of 376 and 375 each give a capture on exactly the 376th or 375th strobe, respectively.
- R5: The queue holds up to 5 values and returns them in capture order. `rts_out` shows the oldest stored value, `rts_valid` is 1 while the queue is not empty, and a one-cycle `pop` removes the oldest value.
- R6: A capture that arrives while 5 values are stored and no pop is made is dropped, and the stored values are unchanged. It also sets `overflow` to 1, and `overflow` stays at 1 until reset.
- R7: A pop while the queue is empty sets `underflow` to 1, and `underflow` stays at 1 until reset. Such a pop has no other effect.
- R8: A synchronous reset (`rst` high at a clock edge) clears the residue counter, the byte count, the queue and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_in | input | 1 | Divided-down network reference clock, asynchronous |
| byte_stb | input | 1 | One-cycle strobe per service payload byte |
| term_count | input | TC_W (9) | Payload bytes per 8-cell period |
| pop | input | 1 | Remove the oldest stored time stamp |
| rts_out | output | RES_W (4) | Oldest stored time stamp |
| rts_valid | output | 1 | Queue holds at least one value |
| overflow | output | 1 | Sticky: a capture was dropped |
| underflow | output | 1 | Sticky: pop made on an empty queue |

## Verification
The bench builds the block with its defaults: a 4-bit residue, a 9-bit terminal count, a 5-entry queue and a two-stage synchronizer. A 9-bit count reaches both 376 and 375, so the real period lengths are run in full. Small terminal counts of 3 and 4 fill the queue quickly, which brings ordering, dropped captures and wrap of the residue past 15 within a short run. A mid-period change of the terminal count shows that a new value waits for the next reload.

// File: rtl/rts_pkg.sv
package rts_pkg;
   localparam int RTS_RES_W   = 4;
   localparam int RTS_TC_W    = 9;
   localparam int RTS_DEPTH   = 5;
   localparam int RTS_SYNC_ST = 2;

   function automatic int ring_next(input int idx, input int depth);
      return (idx == depth - 1) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/rts_ref_counter.sv
module rts_ref_counter #(
   parameter int RES_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_in,
   output logic [RES_W-1:0] residue
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("RES_W must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (rst) residue <= '0;
      else if (rise) residue <= residue + RES_W'(1);
   end

   // R1: the residue only holds or steps up by one
   assert_res_step_R1: assert property (@(posedge clk) disable iff (rst)
      (residue == $past(residue)) || (residue == $past(residue) + RES_W'(1)));
endmodule

// File: rtl/rts_byte_divider.sv
module rts_byte_divider #(
   parameter int TC_W = 9
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            byte_stb,
   input  logic [TC_W-1:0] term_count,
   output logic            latch
);
   generate
      if (TC_W < 2) begin : g_bad_tc
         $error("TC_W must be at least 2");
      end
   endgenerate

   logic [TC_W-1:0] cnt;
   logic [TC_W-1:0] term_active;

   assign latch = byte_stb && (cnt == term_active - TC_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt         <= '0;
         term_active <= term_count;
      end else if (latch) begin
         cnt         <= '0;
         term_active <= term_count;
      end else if (byte_stb) begin
         cnt <= cnt + TC_W'(1);
      end
   end

   // R2: the byte count restarts after every capture
   assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
      latch |=> (cnt == '0));
   // R2: a strobe that does not complete the period advances the count
   assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
      (byte_stb && !latch) |=> (cnt == $past(cnt) + TC_W'(1)));
endmodule

// File: rtl/rts_fifo.sv
module rts_fifo
   import rts_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int DEPTH = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             not_empty,
   output logic             overflow,
   output logic             underflow
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             full, empty, pop_ok, push_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         count     <= '0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
         if (pop_ok)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
         if (push && !push_ok) overflow  <= 1'b1;
         if (pop && empty)     underflow <= 1'b1;
      end
   end

   assign head      = mem[rd_ptr];
   assign not_empty = !empty;

   // R5: occupancy never exceeds the depth
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(DEPTH));
   // R6: a capture into a full queue leaves it full and flags it
   assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
      (push && full && !pop) |=> (full && overflow));
   // R6: overflow is sticky
   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);
   // R7: a pop on an empty queue flags underflow and keeps it set
   assert_unf_R7: assert property (@(posedge clk) disable iff (rst)
      (pop && empty) |=> (underflow && $stable(rd_ptr)));
endmodule

// File: rtl/rts_stamp_gen.sv
module rts_stamp_gen
   import rts_pkg::*;
#(
   parameter int RES_W       = RTS_RES_W,
   parameter int TC_W        = RTS_TC_W,
   parameter int DEPTH       = RTS_DEPTH,
   parameter int SYNC_STAGES = RTS_SYNC_ST
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_clk_in,
   input  logic             byte_stb,
   input  logic [TC_W-1:0]  term_count,
   input  logic             pop,
   output logic [RES_W-1:0] rts_out,
   output logic             rts_valid,
   output logic             overflow,
   output logic             underflow
);
   logic [RES_W-1:0] residue;
   logic             latch;

   rts_ref_counter #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) u_ref (
      .clk(clk), .rst(rst), .ref_in(ref_clk_in), .residue(residue));

   rts_byte_divider #(.TC_W(TC_W)) u_div (
      .clk(clk), .rst(rst), .byte_stb(byte_stb), .term_count(term_count),
      .latch(latch));

   rts_fifo #(.WIDTH(RES_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(latch), .push_data(residue), .pop(pop),
      .head(rts_out), .not_empty(rts_valid), .overflow(overflow),
      .underflow(underflow));

   // R8: flags read clear in the cycle after reset
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (!overflow && !underflow && !rts_valid));
endmodule

// File: tb/tb_rts_stamp_gen.sv
module tb_rts_stamp_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_clk_in = 1'b0;
   logic       byte_stb = 1'b0;
   logic [8:0] term_count = 9'd4;
   logic       pop = 1'b0;
   logic [3:0] rts_out;
   logic       rts_valid, overflow, underflow;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_res  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   rts_stamp_gen dut (
      .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .byte_stb(byte_stb),
      .term_count(term_count), .pop(pop), .rts_out(rts_out),
      .rts_valid(rts_valid), .overflow(overflow), .underflow(underflow));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      exp_res = 0;
   endtask

   task automatic rises(input int n);
      for (int i = 0; i < n; i++) begin
         ref_clk_in = 1'b1; repeat (3) @(negedge clk);
         ref_clk_in = 1'b0; repeat (3) @(negedge clk);
         exp_res = (exp_res + 1) % 16;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic bytes(input int n);
      for (int i = 0; i < n; i++) begin
         byte_stb = 1'b1; @(negedge clk);
      end
      byte_stb = 1'b0;
   endtask

   task automatic pop_one();
      pop = 1'b1; @(negedge clk); pop = 1'b0;
   endtask

   task automatic t_reset();
      term_count = 9'd4;
      do_reset();
      chk("R8 valid after reset", rts_valid, 0);
      chk("R8 overflow after reset", overflow, 0);
      chk("R8 underflow after reset", underflow, 0);
   endtask

   task automatic t_count();
      rises(5);
      bytes(3);
      chk("R2 no capture before Nth strobe", rts_valid, 0);
      bytes(1);
      chk("R2 capture on Nth strobe", rts_valid, 1);
      chk("R1 residue after 5 edges", rts_out, 5);
      pop_one();
      chk("R5 empty after pop", rts_valid, 0);
   endtask

   task automatic t_wrap();
      rises(14);
      bytes(4);
      chk("R1 residue wraps modulo 16", rts_out, 3);
      pop_one();
   endtask

   task automatic t_term_change();
      bytes(2);
      term_count = 9'd3;
      bytes(2);
      chk("R3 period in progress keeps old count", rts_valid, 1);
      pop_one();
      bytes(2);
      chk("R3 new count not yet reached", rts_valid, 0);
      bytes(1);
      chk("R3 new count used after reload", rts_valid, 1);
      chk("R1 residue value", rts_out, exp_res);
      pop_one();
   endtask

   task automatic t_order();
      int vals[5];
      for (int i = 0; i < 5; i++) begin
         rises(i + 1);
         vals[i] = exp_res;
         bytes(3);
      end
      for (int i = 0; i < 5; i++) begin
         chk("R5 capture order", rts_out, vals[i]);
         pop_one();
      end
      chk("R5 empty after draining", rts_valid, 0);
   endtask

   task automatic t_overflow();
      int vals[5];
      for (int i = 0; i < 6; i++) begin
         rises(1);
         if (i < 5) vals[i] = exp_res;
         bytes(3);
      end
      chk("R6 overflow set by dropped capture", overflow, 1);
      for (int i = 0; i < 5; i++) begin
         chk("R6 stored values unchanged", rts_out, vals[i]);
         pop_one();
      end
      chk("R6 sixth capture not stored", rts_valid, 0);
      chk("R6 overflow sticky", overflow, 1);
   endtask

   task automatic t_underflow();
      do_reset();
      chk("R8 reset clears overflow", overflow, 0);
      pop_one();
      chk("R7 underflow on empty pop", underflow, 1);
      chk("R7 queue still empty", rts_valid, 0);
      rises(2);
      bytes(3);
      chk("R7 queue works after underflow", rts_out, 2);
      chk("R7 underflow sticky", underflow, 1);
      pop_one();
   endtask

   task automatic t_reset_clear();
      rises(3);
      bytes(2);
      do_reset();
      chk("R8 reset clears underflow", underflow, 0);
      bytes(2);
      chk("R8 byte count cleared", rts_valid, 0);
      bytes(1);
      chk("R8 capture after full period", rts_valid, 1);
      chk("R8 residue cleared", rts_out, 0);
      pop_one();
   endtask

   task automatic t_long();
      term_count = 9'd376;
      do_reset();
      bytes(375);
      chk("R4 no capture at 375 of 376", rts_valid, 0);
      bytes(1);
      chk("R4 capture at 376", rts_valid, 1);
      pop_one();
      term_count = 9'd375;
      bytes(375);
      chk("R3 period still 376 after change", rts_valid, 0);
      bytes(1);
      chk("R3 capture at 376 before reload", rts_valid, 1);
      pop_one();
      bytes(374);
      chk("R4 no capture at 374 of 375", rts_valid, 0);
      bytes(1);
      chk("R4 capture at 375", rts_valid, 1);
      pop_one();
   endtask

   initial begin
      t_reset();
      t_count();
      t_wrap();
      t_term_change();
      t_order();
      t_overflow();
      t_underflow();
      t_reset_clear();
      t_long();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule